// File: doc/BRIEF.md
# Layered LDPC Decode Sequencer

This block steps a layered LDPC decoder through one frame at a time. It notes when a frame begins and ends on the input stream. It then counts layers within each iteration and counts iterations, driven by a per-layer completion strobe from the external datapath. Each strobe comes with a flag that says whether every check in that layer was satisfied. The block stops decoding after the requested number of iterations. In early mode it stops sooner, at the first iteration in which every layer reported satisfied checks.

When decoding ends, the block plays out an output frame of configurable length. The frame is marked with valid, first-beat and last-beat qualifiers. The number of iterations used and the final parity status are held steady with it. A ready output tells the upstream source when a new frame start is welcome: always when idle, and during the last few output beats. A start that arrives while ready is low throws away the frame in progress and restarts on the new data.

Top module: `ldpc_iter_ctrl`

## Requirements
- R1: The 8-bit requested iteration count is latched at frame start. Values 1 to 63 are used as given. A value of 0, or any value above 63, is replaced by 8.
- R2: With `cfg_early`=0, decoding consumes exactly N×L layer strobes, where N is the iteration count after R1 and L is `cfg_layers`. `out_iters` then equals N, and `out_ok` is the AND of the layer flags of the last iteration.
- R3: With `cfg_early`=1, decoding ends after the first iteration whose layer flags were all 1, or after N iterations, whichever is sooner. `out_iters` reports the count used, and `out_ok` is 1 only if that final iteration was satisfied.
- R4: An iteration counts as satisfied only if every one of its L flags was 1. A flag of 0 in one iteration has no effect on the verdict for the next iteration.
- R5: While `dec_busy` is 1, `lyr_idx` shows the layer now expected (0 to L−1) and `iter_idx` shows the iteration (0-based). After the strobe for layer L−1, the layer count returns to 0 and the iteration count advances.
- R6: `ready` is 1 in idle. It is 0 from an accepted start through loading and decoding. During output it is 1 exactly on the beats where the remaining beats, counting the current one, number `READY_LEAD` or fewer.
- R7: After decoding, `out_valid` is high for `cfg_len` consecutive cycles. `out_start` marks the first of these beats and `out_end` the last. `out_iters` and `out_ok` stay unchanged from one `out_start` until the next.
- R8: A start (`in_valid` and `in_start`) while `ready` is 0 discards the frame in progress. Any output beats of that frame stop in the next cycle. The new frame is then processed from its beginning.
- R9: A start accepted while `ready` is 1 during output leaves the current output frame to finish all its beats. The new frame loads meanwhile.
- R10: Layer strobes are ignored outside decoding, including during loading.
- R11: Loading ends with the beat carrying `in_valid` and `in_end`, which may be the start beat itself. Decoding begins in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input beat qualifier |
| in_start | input | 1 | First beat of an input frame |
| in_end | input | 1 | Last beat of an input frame |
| cfg_layers | input | LAYER_W | Layers per iteration, latched at start (nonzero) |
| cfg_iters | input | 8 | Requested iteration count, latched at start |
| cfg_early | input | 1 | 1 = stop at first satisfied iteration |
| cfg_len | input | LEN_W | Output beats per frame, latched at start (nonzero) |
| lyr_done | input | 1 | Datapath finished one layer |
| lyr_ok | input | 1 | All checks of that layer satisfied |
| ready | output | 1 | A new frame start may be sent |
| dec_busy | output | 1 | Decoding in progress |
| lyr_idx | output | LAYER_W | Current layer index |
| iter_idx | output | 6 | Current iteration index |
| out_valid | output | 1 | Output beat qualifier |
| out_start | output | 1 | First output beat |
| out_end | output | 1 | Last output beat |
| out_iters | output | 6 | Iterations used for the frame being output |
| out_ok | output | 1 | Final parity status for the frame being output |

## Verification
The main sweep crosses layer counts of 1 to 3 with requested counts that lie inside the legal range, at its edges, and outside it. It runs each in both termination modes, with the first satisfied iteration placed at 0, 1, 2 or never. Comparing the strobe counts and reported counts across these settings separates the clamp, the fixed-count stop and the early stop. A failing last layer in each early iteration shows that a verdict does not carry from one iteration into the next. Strobes sent on every other cycle, and strobes during loading, show that only decoding-state strobes advance the counters. Dedicated sequences restart a frame during decoding and during the early part of output, and start a frame in the ready window of output. These separate the discard path from the overlapped path.

// File: rtl/ldpc_ctl_pkg.sv
package ldpc_ctl_pkg;

  localparam int unsigned REQ_W     = 8;
  localparam int unsigned ITER_W    = 6;
  localparam int unsigned ITER_TOP  = 63;
  localparam int unsigned ITER_DFLT = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DEC,
    ST_HOLD,
    ST_OUT
  } ctl_state_t;

  // Out-of-range iteration requests fall back to the default count.
  function automatic logic [ITER_W-1:0] clamp_iters(input logic [REQ_W-1:0] req);
    if (req == '0 || req > REQ_W'(ITER_TOP))
      return ITER_W'(ITER_DFLT);
    return req[ITER_W-1:0];
  endfunction

endpackage

// File: rtl/ldpc_iter_cnt.sv
module ldpc_iter_cnt
  import ldpc_ctl_pkg::*;
#(
  parameter int unsigned LAYER_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               en,
  input  logic               lyr_done,
  input  logic               lyr_ok,
  input  logic [LAYER_W-1:0] n_layers,
  input  logic [ITER_W-1:0]  n_iters,
  input  logic               early,
  output logic [LAYER_W-1:0] layer,
  output logic [ITER_W-1:0]  iter,
  output logic               fin,
  output logic [ITER_W-1:0]  fin_used,
  output logic               fin_ok
);

  logic acc;
  logic step, last_lyr, last_it, it_ok, iter_end;

  always_comb begin
    step     = en & lyr_done;
    last_lyr = (layer == n_layers - LAYER_W'(1));
    last_it  = (iter == n_iters - ITER_W'(1));
    it_ok    = acc & lyr_ok;
    iter_end = step & last_lyr;
    fin      = iter_end & ((early & it_ok) | last_it);
    fin_used = iter + ITER_W'(1);
    fin_ok   = it_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      layer <= '0;
      iter  <= '0;
      acc   <= 1'b1;
    end else if (clr) begin
      layer <= '0;
      iter  <= '0;
      acc   <= 1'b1;
    end else if (step) begin
      if (last_lyr) begin
        if (!fin) begin
          layer <= '0;
          iter  <= iter + ITER_W'(1);
          acc   <= 1'b1;
        end
      end else begin
        layer <= layer + LAYER_W'(1);
        acc   <= it_ok;
      end
    end
  end

  a_r5_layer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (en && n_layers != '0) |-> (layer < n_layers));
  a_r2_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (en && n_iters != '0) |-> (iter < n_iters));
  a_r2_fixed_count: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !early) |-> (fin_used == n_iters));
  a_r3_early_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && early && fin_used != n_iters) |-> fin_ok);
  a_r4_wrap_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_end && !fin && !clr) |=> (layer == '0 && iter == $past(iter) + ITER_W'(1)));

endmodule

// File: rtl/ldpc_out_seq.sv
module ldpc_out_seq #(
  parameter int unsigned LEN_W      = 12,
  parameter int unsigned READY_LEAD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             flush,
  input  logic [LEN_W-1:0] len_in,
  output logic             busy,
  output logic             first,
  output logic             last,
  output logic             tail
);

  logic [LEN_W-1:0] cnt, len_q, rem;

  always_comb begin
    rem   = len_q - cnt;
    first = busy & (cnt == '0);
    last  = busy & (cnt == len_q - LEN_W'(1));
    tail  = busy & (rem <= LEN_W'(READY_LEAD));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      len_q <= '0;
    end else if (flush) begin
      busy <= 1'b0;
    end else if (launch) begin
      busy  <= 1'b1;
      cnt   <= '0;
      len_q <= len_in;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      cnt  <= cnt + LEN_W'(1);
    end
  end

  a_r7_launch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy);
  a_r7_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < len_q));
  a_r7_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last && !flush) |=> busy);

endmodule

// File: rtl/ldpc_iter_ctrl.sv
module ldpc_iter_ctrl
  import ldpc_ctl_pkg::*;
#(
  parameter int unsigned LAYER_W    = 8,
  parameter int unsigned LEN_W      = 12,
  parameter int unsigned READY_LEAD = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_start,
  input  logic               in_end,
  input  logic [LAYER_W-1:0] cfg_layers,
  input  logic [7:0]         cfg_iters,
  input  logic               cfg_early,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic               lyr_done,
  input  logic               lyr_ok,
  output logic               ready,
  output logic               dec_busy,
  output logic [LAYER_W-1:0] lyr_idx,
  output logic [5:0]         iter_idx,
  output logic               out_valid,
  output logic               out_start,
  output logic               out_end,
  output logic [5:0]         out_iters,
  output logic               out_ok
);

  ctl_state_t state, state_nx;

  logic [LAYER_W-1:0] layers_q;
  logic [ITER_W-1:0]  iters_q;
  logic               early_q;
  logic [LEN_W-1:0]   len_q;
  logic [ITER_W-1:0]  p_used;
  logic               p_ok;

  // named internal events
  logic start_ev, end_ev, abort_ev, launch_ev, flush_ev;
  logic fin, fin_ok;
  logic [ITER_W-1:0] fin_used;
  logic eng_busy, eng_first, eng_last, eng_tail;

  always_comb begin
    start_ev  = in_valid & in_start;
    end_ev    = in_valid & in_end;
    ready     = (state == ST_IDLE) | ((state == ST_OUT) & eng_tail);
    abort_ev  = start_ev & ~ready;
    launch_ev = (state == ST_HOLD) & ~eng_busy & ~start_ev;
    flush_ev  = abort_ev & (state == ST_OUT);
  end

  always_comb begin
    state_nx = state;
    if (start_ev) begin
      state_nx = end_ev ? ST_DEC : ST_LOAD;
    end else begin
      unique case (state)
        ST_LOAD: if (end_ev)    state_nx = ST_DEC;
        ST_DEC:  if (fin)       state_nx = ST_HOLD;
        ST_HOLD: if (!eng_busy) state_nx = ST_OUT;
        ST_OUT:  if (eng_last)  state_nx = ST_IDLE;
        default: state_nx = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      layers_q <= LAYER_W'(1);
      iters_q  <= ITER_W'(ITER_DFLT);
      early_q  <= 1'b0;
      len_q    <= LEN_W'(1);
      p_used   <= '0;
      p_ok     <= 1'b0;
      out_iters <= '0;
      out_ok   <= 1'b0;
    end else begin
      state <= state_nx;
      if (start_ev) begin
        layers_q <= cfg_layers;
        iters_q  <= clamp_iters(cfg_iters);
        early_q  <= cfg_early;
        len_q    <= cfg_len;
      end
      if (fin && !start_ev) begin
        p_used <= fin_used;
        p_ok   <= fin_ok;
      end
      if (launch_ev) begin
        out_iters <= p_used;
        out_ok    <= p_ok;
      end
    end
  end

  ldpc_iter_cnt #(.LAYER_W(LAYER_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_ev),
    .en       (state == ST_DEC),
    .lyr_done (lyr_done),
    .lyr_ok   (lyr_ok),
    .n_layers (layers_q),
    .n_iters  (iters_q),
    .early    (early_q),
    .layer    (lyr_idx),
    .iter     (iter_idx),
    .fin      (fin),
    .fin_used (fin_used),
    .fin_ok   (fin_ok)
  );

  ldpc_out_seq #(.LEN_W(LEN_W), .READY_LEAD(READY_LEAD)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch_ev),
    .flush  (flush_ev),
    .len_in (len_q),
    .busy   (eng_busy),
    .first  (eng_first),
    .last   (eng_last),
    .tail   (eng_tail)
  );

  always_comb begin
    dec_busy  = (state == ST_DEC);
    out_valid = eng_busy;
    out_start = eng_first;
    out_end   = eng_last;
  end

  a_r6_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> ready);
  a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    dec_busy |-> !ready);
  a_r8_abort_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_ev && state == ST_OUT) |=> !out_valid);
  a_r8_abort_restart: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (state == ST_LOAD || state == ST_DEC));
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_start) |-> ($stable(out_iters) && $stable(out_ok)));
  a_r10_idle_counters: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_busy && !start_ev) |=> ($stable(lyr_idx) && $stable(iter_idx)));
  a_r1_legal_count: assert property (@(posedge clk) disable iff (!rst_n)
    dec_busy |-> (iters_q >= ITER_W'(1)));

endmodule

// File: tb/sim_ldpc_iter_ctrl.sv
module sim_ldpc_iter_ctrl;

  localparam int LW   = 8;
  localparam int NW   = 12;
  localparam int LEAD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic in_valid = 0, in_start = 0, in_end = 0;
  logic [LW-1:0] cfg_layers = 1;
  logic [7:0]    cfg_iters = 1;
  logic          cfg_early = 0;
  logic [NW-1:0] cfg_len = 1;
  logic lyr_done = 0, lyr_ok = 0;
  logic ready, dec_busy, out_valid, out_start, out_end, out_ok;
  logic [LW-1:0] lyr_idx;
  logic [5:0] iter_idx, out_iters;

  ldpc_iter_ctrl #(.LAYER_W(LW), .LEN_W(NW), .READY_LEAD(LEAD)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_end(in_end), .cfg_layers(cfg_layers), .cfg_iters(cfg_iters),
    .cfg_early(cfg_early), .cfg_len(cfg_len), .lyr_done(lyr_done),
    .lyr_ok(lyr_ok), .ready(ready), .dec_busy(dec_busy), .lyr_idx(lyr_idx),
    .iter_idx(iter_idx), .out_valid(out_valid), .out_start(out_start),
    .out_end(out_end), .out_iters(out_iters), .out_ok(out_ok)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int g_L, g_sat, g_used, g_ok, g_len, g_ns;
  bit g_gap;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampN(int r);
    return (r < 1 || r > 63) ? 8 : r;
  endfunction

  // drive an input frame of nin beats; strobes during load must be ignored (R10)
  task automatic drive_input(int L, int req, bit early, int sat, int len, bit gap, int nin);
    int nc;
    nc = clampN(req);
    g_L = L; g_sat = sat; g_len = len; g_gap = gap;
    g_used = early ? ((sat < nc) ? sat + 1 : nc) : nc;
    g_ok = (sat <= g_used - 1) ? 1 : 0;
    for (int k = 0; k < nin; k++) begin
      in_valid = 1; in_start = (k == 0); in_end = (k == nin - 1);
      cfg_layers = LW'(L); cfg_iters = 8'(req); cfg_early = early; cfg_len = NW'(len);
      lyr_done = 1; lyr_ok = 0;
      @(negedge clk);
      if (k == 0) chk("R6 ready low after start", int'(ready), 0);
      chk("R11 decode begins only after end beat", int'(dec_busy), (k == nin - 1) ? 1 : 0);
    end
    in_valid = 0; in_start = 0; in_end = 0; lyr_done = 0;
  endtask

  // issue layer strobes while decoding until the output frame starts
  task automatic strobe_phase();
    int bi, bl, to;
    bit tog;
    bi = 0; bl = 0; to = 0; tog = 1; g_ns = 0;
    while (!out_start && to < 6000) begin
      if (dec_busy) begin
        chk("R5 layer index", int'(lyr_idx), bl);
        chk("R5 iteration index", int'(iter_idx), bi);
        if (!g_gap || tog) begin
          lyr_done = 1;
          lyr_ok = (bi >= g_sat) || (bl != g_L - 1);
          g_ns++;
          bl++;
          if (bl == g_L) begin bl = 0; bi++; end
        end else begin
          lyr_done = 0;
        end
        tog = !tog;
      end else begin
        lyr_done = 0;
      end
      @(negedge clk);
      to++;
    end
    lyr_done = 0;
    chk("R1 R2 R3 strobes consumed", g_ns, g_used * g_L);
    chk("R2 R3 out_iters", int'(out_iters), g_used);
    chk("R2 R3 R4 out_ok", int'(out_ok), g_ok);
  endtask

  task automatic check_output(int from_beat);
    for (int k = from_beat; k < g_len; k++) begin
      chk("R7 out_valid", int'(out_valid), 1);
      chk("R7 out_start", int'(out_start), (k == 0) ? 1 : 0);
      chk("R7 out_end", int'(out_end), (k == g_len - 1) ? 1 : 0);
      chk("R7 out_iters held", int'(out_iters), g_used);
      chk("R6 ready window", int'(ready), (g_len - k <= LEAD) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic run_frame(int L, int req, bit early, int sat, int len, bit gap, int nin);
    drive_input(L, req, early, sat, len, gap, nin);
    strobe_phase();
    check_output(0);
    chk("R7 out_valid low after frame", int'(out_valid), 0);
    chk("R6 ready in idle", int'(ready), 1);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int reqs[6];
    int sats[4];
    int nst;
    reqs = '{0, 1, 3, 63, 64, 200};
    sats = '{0, 1, 2, 100};
    repeat (3) @(negedge clk);
    chk("R6 ready after reset", int'(ready), 1);
    chk("R7 out_valid after reset", int'(out_valid), 0);
    chk("R5 dec_busy after reset", int'(dec_busy), 0);
    rst_n = 1;
    @(negedge clk);

    // main sweep: R1 R2 R3 R4 R5 R10 R11
    for (int L = 1; L <= 3; L++)
      for (int ri = 0; ri < 6; ri++)
        for (int e = 0; e < 2; e++)
          for (int si = 0; si < 4; si++)
            run_frame(L, reqs[ri], e[0], sats[si], 1 + ((L + si) % 4),
                      (si + ri) % 2 == 1, 1 + (si % 3));

    // R8: restart during decoding
    drive_input(2, 10, 0, 0, 3, 0, 1);
    for (int k = 0; k < 5; k++) begin
      lyr_done = 1; lyr_ok = 1;
      @(negedge clk);
    end
    lyr_done = 0;
    chk("R8 still decoding before restart", int'(dec_busy), 1);
    run_frame(3, 2, 1, 1, 4, 0, 2);

    // R8: restart during the early part of output
    drive_input(1, 1, 0, 0, 10, 0, 1);
    strobe_phase();
    check_output(0);
    // check_output consumed all beats; issue a fresh long frame and cut it
    drive_input(1, 1, 0, 0, 10, 0, 1);
    strobe_phase();
    for (int k = 0; k < 3; k++) @(negedge clk);
    chk("R8 ready low mid output", int'(ready), 0);
    drive_input(2, 3, 0, 5, 3, 0, 1);
    chk("R8 output cut after restart", int'(out_valid), 0);
    strobe_phase();
    check_output(0);
    chk("R8 idle after restarted frame", int'(ready), 1);

    // R9: start inside the ready window of output
    drive_input(1, 2, 0, 0, 6, 0, 1);
    strobe_phase();
    for (int k = 0; k < 4; k++) @(negedge clk);
    chk("R9 ready in tail", int'(ready), 1);
    drive_input(1, 1, 0, 0, 2, 0, 1);
    chk("R9 old frame keeps beating", int'(out_valid), 1);
    chk("R9 old frame last beat", int'(out_end), 1);
    nst = 0;
    strobe_phase();
    check_output(0);
    chk("R9 idle at end", int'(ready), 1);
    nst = nst + 1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule